// File: doc/BRIEF.md
# Memory pattern march sequencer

This block drives a 32-bit word memory port to exercise memory cells. After a start pulse it writes a region with a generated data stream and then reads the same region back, checking every word against the value it regenerates. It does this seven times in a row, with a different data generator each time. The first word that reads back wrong ends the test. The block then reports the byte address of that word, the value it expected and the value it read.

A mode input picks between two kinds of coverage. Full mode sweeps the whole region once. Sparse mode visits only two 2 KiB windows around each megabyte boundary inside the region. While it runs, the block sends a short keep-alive pulse at regular word intervals so that an external watchdog is not starved during a long sweep. The attached memory returns read data exactly one cycle after a read request.

Top module: `mem_march_seq`

## Requirements
- R1: Every window gets seven passes in this fixed order, numbered 0 to 6. Pass 0 writes 0x00000000. Pass 1 writes 0xFFFFFFFF. Pass 2 writes 0x55555555. Pass 3 writes 0xAAAAAAAA. Pass 4 writes a single one at bit (index mod 32). Pass 5 writes the word index. Pass 6 writes the bitwise inverse of the word index.
- R2: In each pass the block first writes every word of the window in ascending index order. Only then does it read every word back in the same order. Word k sits at byte address window base + 4·k. Read data is taken one cycle after the read request.
- R3: The first word that reads back wrong ends the whole test. No further memory access is made after that read. pass_o is low at done, and fail_addr_o, fail_exp_o and fail_act_o hold the failing byte address, the expected word and the word read. These stay unchanged until the next accepted start.
- R4: keep_alive_o pulses together with any access (write or read) whose window word index is a multiple of 1024. It is never high in a cycle without an access.
- R5: In sparse mode, each whole megabyte i of the size is handled in ascending order. The block tests 2048 bytes at base + i·0x100000, then 2048 bytes at base + i·0x100000 + 0xFF800.
- R6: In full mode, a single window starts at base and covers size/4 words.
- R7: In sparse mode, a failing window ends the test and no later window is started.
- R8: The word index used for addresses and for the data of passes 4 to 6 restarts at 0 at the start of every pass of every window.
- R9: In sparse mode, any part of the size below a whole megabyte is not tested. If there is no whole megabyte (sparse mode), or the size is below 4 (full mode), done comes with pass_o high and no memory access is made.
- R10: busy_o rises in the cycle after an accepted start. done_o is a one-cycle pulse in whose cycle busy_o is already low. pass_o is valid at done and holds until the next start.
- R11: A start pulse while busy_o is high is ignored. The running test and its access stream are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| sparse_i | input | 1 | 1 = windows around megabyte boundaries, 0 = whole region |
| base_i | input | 32 | Region base byte address (word aligned) |
| size_i | input | 32 | Region size in bytes |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Test finished with no mismatch |
| fail_addr_o | output | 32 | Byte address of the failing word |
| fail_exp_o | output | 32 | Expected word at the failure |
| fail_act_o | output | 32 | Word read at the failure |
| keep_alive_o | output | 1 | Watchdog keep-alive pulse |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read request |

## Verification
Two events can land in the same cycle: the compare that detects a bad word, and the issue of the next read, which may carry a keep-alive pulse. The bench provokes this with a stuck-low bit at word 1023 of a 2048-word full sweep. Pass 1 then fails at the read of word 1023, and that compare falls in the very cycle in which the read of word 1024, with its keep-alive, would go out. The scoreboard expects the access stream to end at word 1023 with no further access and no pulse, and expects the report to show 0xFFFFFFFF expected against 0xFFFFFFFE read.

// File: rtl/mem_march_pkg.sv
// Shared types for the memory pattern march sequencer.
// Assumes: pass numbering order is behaviour (fixed test schedule).
package mem_march_pkg;
    localparam int NUM_PASSES = 7;

    typedef enum logic [2:0] {
        PAT_ZERO    = 3'd0,
        PAT_ONES    = 3'd1,
        PAT_ALT01   = 3'd2,
        PAT_ALT10   = 3'd3,
        PAT_WALK    = 3'd4,
        PAT_INDEX   = 3'd5,
        PAT_INDEX_N = 3'd6
    } pat_kind_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_FILL,
        ENG_CHECK,
        ENG_DRAIN
    } eng_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LAUNCH,
        SEQ_WAIT
    } seq_state_e;
endpackage

// File: rtl/mem_march_patgen.sv
// Data generator: maps a pass kind and a word index to the test word.
// Assumes: DATA_W is a power of two and even.
module mem_march_patgen
    import mem_march_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 30
) (
    input  pat_kind_e         kind_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] idx_ext;
    logic [DATA_W-1:0] one_hot;

    // Widen the index to a data word and build the walking bit.
    always_comb begin
        idx_ext = DATA_W'(idx_i);
        one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << idx_i[SH_W-1:0];
    end

    // Select the word for the current pass.
    always_comb begin
        case (kind_i)
            PAT_ZERO:    data_o = '0;
            PAT_ONES:    data_o = '1;
            PAT_ALT01:   data_o = {(DATA_W/2){2'b01}};
            PAT_ALT10:   data_o = {(DATA_W/2){2'b10}};
            PAT_WALK:    data_o = one_hot;
            PAT_INDEX:   data_o = idx_ext;
            PAT_INDEX_N: data_o = ~idx_ext;
            default:     data_o = '0;
        endcase
    end
endmodule

// File: rtl/mem_march_window.sv
// Window planner: turns mode, region and window position into the
// base address and word count of the window to test next.
// Assumes: base is word aligned; WIN_BYTES is a multiple of 4 and below 1 MiB.
module mem_march_window #(
    parameter int ADDR_W    = 32,
    parameter int MB_SHIFT  = 20,
    parameter int WIN_BYTES = 2048,
    localparam int IDX_W    = ADDR_W - 2,
    localparam int MBI_W    = ADDR_W - MB_SHIFT
) (
    input  logic              sparse_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] size_i,
    input  logic [MBI_W-1:0]  mb_idx_i,
    input  logic              half_i,
    output logic [ADDR_W-1:0] wbase_o,
    output logic [IDX_W-1:0]  nwords_o,
    output logic [MBI_W-1:0]  mb_count_o,
    output logic              empty_o
);
    localparam logic [ADDR_W-1:0] MB_BYTES  = ADDR_W'(1) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] HI_OFS    = MB_BYTES - ADDR_W'(WIN_BYTES);
    localparam logic [IDX_W-1:0]  WIN_WORDS = IDX_W'(WIN_BYTES / 4);

    logic [ADDR_W-1:0] mb_ofs;

    // Whole megabytes in the size and the offset of the current one.
    always_comb begin
        mb_count_o = size_i[ADDR_W-1:MB_SHIFT];
        mb_ofs     = {mb_idx_i, {MB_SHIFT{1'b0}}};
    end

    // Window base, length and the nothing-to-test flag per mode.
    always_comb begin
        if (sparse_i) begin
            wbase_o  = base_i + mb_ofs + (half_i ? HI_OFS : '0);
            nwords_o = WIN_WORDS;
            empty_o  = (mb_count_o == '0);
        end else begin
            wbase_o  = base_i;
            nwords_o = size_i[ADDR_W-1:2];
            empty_o  = (size_i[ADDR_W-1:2] == '0);
        end
    end
endmodule

// File: rtl/mem_march_engine.sv
// Pass engine: runs the seven fill-then-verify passes over one window,
// stops at the first mismatch and raises keep-alive on indexed accesses.
// Assumes: read data arrives one cycle after a read request; nwords > 0.
module mem_march_engine
    import mem_march_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int KICK_LOG = 10,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] wbase_i,
    input  logic [IDX_W-1:0]  nwords_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_act_o,
    output logic              kick_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    eng_state_e        state_q;
    pat_kind_e         pass_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [ADDR_W-1:0] wbase_q;
    logic              cmp_v_q;
    logic [ADDR_W-1:0] cmp_addr_q;
    logic [DATA_W-1:0] cmp_exp_q;

    logic [DATA_W-1:0] pat_data;
    logic [ADDR_W-1:0] cur_addr;
    logic              mismatch;
    logic              at_last;

    mem_march_patgen #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) patgen_i (
        .kind_i (pass_q),
        .idx_i  (idx_q),
        .data_o (pat_data)
    );

    // Address of the current word, compare of the returning read.
    always_comb begin
        cur_addr = wbase_q + {idx_q, 2'b00};
        mismatch = cmp_v_q && (mem_rdata_i != cmp_exp_q);
        at_last  = (idx_q == last_q);
    end

    // Memory request and keep-alive; a detected mismatch blocks the next read.
    always_comb begin
        mem_en_o    = (state_q == ENG_FILL) || ((state_q == ENG_CHECK) && !mismatch);
        mem_we_o    = (state_q == ENG_FILL);
        mem_addr_o  = cur_addr;
        mem_wdata_o = pat_data;
        kick_o      = mem_en_o && (idx_q[KICK_LOG-1:0] == '0);
    end

    // Pass / phase / index sequencing and failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ENG_IDLE;
            pass_q      <= PAT_ZERO;
            idx_q       <= '0;
            last_q      <= '0;
            wbase_q     <= '0;
            cmp_v_q     <= 1'b0;
            cmp_addr_q  <= '0;
            cmp_exp_q   <= '0;
            done_o      <= 1'b0;
            fail_o      <= 1'b0;
            fail_addr_o <= '0;
            fail_exp_o  <= '0;
            fail_act_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ENG_IDLE: begin
                    cmp_v_q <= 1'b0;
                    if (start_i) begin
                        wbase_q <= wbase_i;
                        last_q  <= nwords_i - 1'b1;
                        idx_q   <= '0;
                        pass_q  <= PAT_ZERO;
                        fail_o  <= 1'b0;
                        state_q <= ENG_FILL;
                    end
                end
                ENG_FILL: begin
                    if (at_last) begin
                        idx_q   <= '0;
                        state_q <= ENG_CHECK;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ENG_CHECK: begin
                    if (mismatch) begin
                        fail_addr_o <= cmp_addr_q;
                        fail_exp_o  <= cmp_exp_q;
                        fail_act_o  <= mem_rdata_i;
                        fail_o      <= 1'b1;
                        done_o      <= 1'b1;
                        state_q     <= ENG_IDLE;
                    end else begin
                        cmp_v_q    <= 1'b1;
                        cmp_addr_q <= cur_addr;
                        cmp_exp_q  <= pat_data;
                        if (at_last) begin
                            state_q <= ENG_DRAIN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ENG_DRAIN: begin
                    cmp_v_q <= 1'b0;
                    if (mismatch) begin
                        fail_addr_o <= cmp_addr_q;
                        fail_exp_o  <= cmp_exp_q;
                        fail_act_o  <= mem_rdata_i;
                        fail_o      <= 1'b1;
                        done_o      <= 1'b1;
                        state_q     <= ENG_IDLE;
                    end else if (pass_q == PAT_INDEX_N) begin
                        done_o  <= 1'b1;
                        state_q <= ENG_IDLE;
                    end else begin
                        pass_q  <= pat_kind_e'(pass_q + 3'd1);
                        idx_q   <= '0;
                        state_q <= ENG_FILL;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mem_march_seq.sv
// Top of the memory pattern march sequencer: accepts a start, walks the
// windows chosen by the mode through the pass engine, reports the result.
// Assumes: size is a multiple of 4; memory read latency is one cycle.
module mem_march_seq
    import mem_march_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MB_SHIFT  = 20,
    parameter int WIN_BYTES = 2048,
    parameter int KICK_LOG  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sparse_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] size_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_act_o,
    output logic              keep_alive_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int MBI_W = ADDR_W - MB_SHIFT;

    seq_state_e        st_q;
    logic              sparse_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] size_q;
    logic [MBI_W-1:0]  mb_q;
    logic              half_q;

    logic [ADDR_W-1:0] win_base;
    logic [IDX_W-1:0]  win_words;
    logic [MBI_W-1:0]  mb_count;
    logic              win_empty;
    logic              eng_start;
    logic              eng_done;
    logic              eng_fail;
    logic              last_window;

    mem_march_window #(
        .ADDR_W    (ADDR_W),
        .MB_SHIFT  (MB_SHIFT),
        .WIN_BYTES (WIN_BYTES)
    ) window_i (
        .sparse_i   (sparse_q),
        .base_i     (base_q),
        .size_i     (size_q),
        .mb_idx_i   (mb_q),
        .half_i     (half_q),
        .wbase_o    (win_base),
        .nwords_o   (win_words),
        .mb_count_o (mb_count),
        .empty_o    (win_empty)
    );

    mem_march_engine #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KICK_LOG (KICK_LOG)
    ) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (eng_start),
        .wbase_i     (win_base),
        .nwords_i    (win_words),
        .done_o      (eng_done),
        .fail_o      (eng_fail),
        .fail_addr_o (fail_addr_o),
        .fail_exp_o  (fail_exp_o),
        .fail_act_o  (fail_act_o),
        .kick_o      (keep_alive_o),
        .mem_en_o    (mem_en_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // Launch the engine unless there is nothing to test; spot the final window.
    always_comb begin
        eng_start   = (st_q == SEQ_LAUNCH) && !win_empty;
        last_window = !sparse_q || (half_q && (mb_q == mb_count - 1'b1));
    end

    // Window walk, busy/done/pass reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SEQ_IDLE;
            sparse_q <= 1'b0;
            base_q   <= '0;
            size_q   <= '0;
            mb_q     <= '0;
            half_q   <= 1'b0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            pass_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        sparse_q <= sparse_i;
                        base_q   <= base_i;
                        size_q   <= size_i;
                        mb_q     <= '0;
                        half_q   <= 1'b0;
                        busy_o   <= 1'b1;
                        pass_o   <= 1'b0;
                        st_q     <= SEQ_LAUNCH;
                    end
                end
                SEQ_LAUNCH: begin
                    if (win_empty) begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                        pass_o <= 1'b1;
                        st_q   <= SEQ_IDLE;
                    end else begin
                        st_q <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (eng_done) begin
                        if (eng_fail || last_window) begin
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                            pass_o <= !eng_fail;
                            st_q   <= SEQ_IDLE;
                        end else begin
                            if (half_q) begin
                                half_q <= 1'b0;
                                mb_q   <= mb_q + 1'b1;
                            end else begin
                                half_q <= 1'b1;
                            end
                            st_q <= SEQ_LAUNCH;
                        end
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mem_march_seq_chk.sv
// Protocol checker for mem_march_seq, attached by bind below.
// Assumes: observes only the top-level ports.
module mem_march_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] fail_addr_o,
    input logic [DATA_W-1:0] fail_exp_o,
    input logic [DATA_W-1:0] fail_act_o,
    input logic              keep_alive_o,
    input logic              mem_en_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    AST_KICK_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |-> mem_en_o); // R4
    AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_en_o); // R3
    AST_REPORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(fail_addr_o) && $stable(fail_exp_o) && $stable(fail_act_o))); // R3
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> (mem_addr_o[1:0] == 2'b00)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R10
endmodule

bind mem_march_seq mem_march_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/mem_march_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task predicts the full access stream of a run,
// a monitor pops and compares each access the design makes.
module mem_march_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sparse_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] size_i = '0;
    logic        busy_o, done_o, pass_o, keep_alive_o;
    logic [31:0] fail_addr_o, fail_exp_o, fail_act_o;
    logic        mem_en_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        bit          kick;
        string       atag;
    } acc_t;
    acc_t q[$];

    logic [31:0] mem [int unsigned];
    bit          f_on;
    logic [31:0] f_addr, f_set, f_clr;
    bit          x_fail;
    logic [31:0] x_addr, x_exp, x_act;

    always #2.5 clk = ~clk;

    mem_march_seq dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model with an optional stuck-bit fault on one address.
    always @(posedge clk) begin
        if (mem_en_o) begin
            if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
            else begin
                logic [31:0] v;
                v = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
                if (f_on && mem_addr_o == f_addr) v = (v | f_set) & ~f_clr;
                mem_rdata_i <= v;
            end
        end
    end

    function automatic logic [31:0] pat(input int p, input logic [31:0] i);
        case (p)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h5555_5555;
            3: return 32'hAAAA_AAAA;
            4: return 32'h1 << (i % 32);
            5: return i;
            default: return ~i;
        endcase
    endfunction

    // Driver: predict one window (R1, R2, R4, R8: index restarts per pass).
    task automatic push_window(input logic [31:0] wb, input int unsigned n, input string atag);
        for (int p = 0; p < 7; p++) begin
            for (int unsigned i = 0; i < n; i++)
                q.push_back('{1'b1, wb + 4*i, pat(p, i), (i % 1024) == 0, atag});
            for (int unsigned i = 0; i < n; i++) begin
                logic [31:0] a, e, r;
                a = wb + 4*i;
                e = pat(p, i);
                r = (f_on && a == f_addr) ? ((e | f_set) & ~f_clr) : e;
                q.push_back('{1'b0, a, e, (i % 1024) == 0, atag});
                if (r != e) begin
                    x_fail = 1; x_addr = a; x_exp = e; x_act = r;
                    return;
                end
            end
        end
    endtask

    task automatic push_run(input bit sp, input logic [31:0] base, input logic [31:0] size);
        x_fail = 0;
        if (sp) begin
            for (int unsigned m = 0; m < (size >> 20) && !x_fail; m++) begin
                push_window(base + (m << 20), 512, "R5");
                if (!x_fail) push_window(base + (m << 20) + 32'hFF800, 512, "R5");
            end
        end else if ((size >> 2) != 0) begin
            push_window(base, size >> 2, "R6");
        end
    endtask

    // Monitor: pop and compare every access away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && mem_en_o) begin
            if (q.size() == 0) begin
                check(0, "R3 access after end of stream", mem_addr_o, 32'h0);
            end else begin
                acc_t it;
                it = q.pop_front();
                check(mem_we_o == it.we, "R2 phase", 32'(mem_we_o), 32'(it.we));
                check(mem_addr_o == it.addr, it.atag, mem_addr_o, it.addr);
                if (it.we) check(mem_wdata_o == it.data, "R1 data", mem_wdata_o, it.data);
                check(keep_alive_o == it.kick, "R4 keep-alive", 32'(keep_alive_o), 32'(it.kick));
            end
        end else if (rst_n && keep_alive_o) begin
            check(0, "R4 keep-alive without access", 32'h1, 32'h0);
        end
    end

    task automatic run_case(input bit sp, input logic [31:0] base, input logic [31:0] size,
                            input bit fon, input logic [31:0] fa, input logic [31:0] fs,
                            input logic [31:0] fc, input bit poke);
        int cyc;
        logic [31:0] ha, he, hr;
        mem.delete();
        q.delete();
        f_on = fon; f_addr = fa; f_set = fs; f_clr = fc;
        push_run(sp, base, size);
        @(negedge clk);
        start_i = 1'b1; sparse_i = sp; base_i = base; size_i = size;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 32'h1);
        cyc = 0;
        while (!done_o && cyc < 60000) begin
            if (poke && cyc == 50) begin start_i = 1'b1; base_i = ~base; sparse_i = ~sp; end
            if (poke && cyc == 51) begin start_i = 1'b0; end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        check(done_o == 1'b1, "R10 done (watchdog)", 32'(done_o), 32'h1);
        check(busy_o == 1'b0, "R10 busy low at done", 32'(busy_o), 32'h0);
        check(pass_o == !x_fail, "R10 pass flag", 32'(pass_o), 32'(!x_fail));
        check(q.size() == 0, sp ? "R7 stream complete" : "R6 stream complete", q.size(), 0);
        if (x_fail) begin
            check(fail_addr_o == x_addr, "R3 fail address", fail_addr_o, x_addr);
            check(fail_exp_o == x_exp, "R3 expected word", fail_exp_o, x_exp);
            check(fail_act_o == x_act, "R3 read word", fail_act_o, x_act);
        end
        ha = fail_addr_o; he = fail_exp_o; hr = fail_act_o;
        @(negedge clk);
        check(done_o == 1'b0, "R10 done single cycle", 32'(done_o), 32'h0);
        repeat (3) @(negedge clk);
        check(fail_addr_o == ha && fail_exp_o == he && fail_act_o == hr, "R3 report held", fail_act_o, hr);
        check(pass_o == !x_fail, "R10 pass held", 32'(pass_o), 32'(!x_fail));
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && done_o == 0 && pass_o == 0, "R10 reset state", {busy_o, done_o, pass_o}, 0);
        check(mem_en_o == 0 && keep_alive_o == 0, "R4 reset quiet", {mem_en_o, keep_alive_o}, 0);
        // R6, R1, R11: full sweep of 2048 words, a start poked mid-run.
        run_case(0, 32'h1000, 32'h2000, 0, 0, 0, 0, 1);
        // R5, R8, R9: two megabytes plus a leftover that is not tested.
        run_case(1, 32'h0, 32'h0020_0100, 0, 0, 0, 0, 0);
        // R3, R4: bit 0 stuck low at word 1023; the compare coincides with a keep-alive read.
        run_case(0, 32'h1000, 32'h2000, 1, 32'h1000 + 4*1023, 0, 32'h1, 0);
        // R7: failure in the upper window of megabyte 0 stops the walk.
        run_case(1, 32'h0, 32'h0020_0000, 1, 32'hFF808, 32'h8000_0000, 0, 0);
        // R9: nothing to test in either mode.
        run_case(1, 32'h0, 32'h0008_0000, 0, 0, 0, 0, 0);
        run_case(0, 32'h40, 32'h2, 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule